// File: doc/BRIEF.md
# Sequenced Palette DAC Register Port

This block is the write side of a 256-entry colour lookup table with a small memory-mapped register port. Software picks an entry by writing an index word. It then sends the entry's red, green and blue intensities one after another to a single data offset. After the third component the block moves to the next entry by itself, so a whole palette can be streamed as one run of data writes after a single index write.

Each component is taken from the most significant byte of a 32-bit bus word. A three-step phase counter decides which component the next data write lands in. A combinational read port gives the display path the stored colour of any entry. Every accepted component write raises an update strobe for one cycle, carrying the entry number, so that downstream copies of the palette can refresh that one entry. Reads of the register window always return zero.

Top module: `pal_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), entries 0 to 254 read as black (0x000000) and entry 255 reads as white (0xFFFFFF). The current index is 0 and the phase is red, so the first data write after reset goes to the red component of entry 0.
- R2: A full-word write to byte offset 0 loads the current index from bus_wdata[31:24] and returns the phase to red. This holds even when a red/green/blue sequence is only partly done.
- R3: Full-word writes to byte offset 4 store bus_wdata[31:24] into the red, then the green, then the blue component of the current entry. pix_color presents red in bits 23:16, green in bits 15:8 and blue in bits 7:0 of the entry chosen by pix_idx. The new value is visible in the cycle after the write edge.
- R4: After the blue write, the index advances by one modulo 256, with 255 followed by 0, and the phase returns to red.
- R5: A write to any other byte offset in the 16-byte window (8, 12 or an address that is not a multiple of four) changes no entry, no index and no phase, and raises no strobe.
- R6: A write whose byte enables bus_be are not all four set (1111) is ignored at every offset.
- R7: bus_rdata is zero at all times.
- R8: Each accepted component write sets upd_valid for exactly the one cycle after its clock edge, with upd_idx equal to the entry written. upd_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe of the register bus |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_be | input | 4 | Byte enables; only 1111 is accepted |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the payload |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Entry selected for the palette read port |
| pix_color | output | 24 | Colour of the selected entry, {red, green, blue} |
| upd_valid | output | 1 | One-cycle strobe after each component write |
| upd_idx | output | 8 | Entry changed by the write that raised upd_valid |

## Verification
The properties assume that bus_we, bus_addr, bus_be and bus_wdata are stable around the clock edge. They also assume that one bus word is presented per cycle, with no notion of a multi-cycle transfer. The bench drives every input half a period away from the rising edge and holds each word for exactly one edge, including back-to-back data writes. This means a strobe can follow every edge. pix_idx is treated as free-running and may change in any cycle. The bench moves it only between edges, after the writes it inspects have settled.

// File: rtl/pal_pkg.sv
// Package: pal_pkg
// Shared types of the palette register port. Holds the phase encoding
// that the sequencer keeps and that the checker decodes by value.
package pal_pkg;

    // Component phase of the data register; PH_BAD is never entered normally.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2,
        PH_BAD = 2'd3
    } phase_e;

    localparam int NUM_COMP = 3;

endpackage

// File: rtl/pal_bus_decode.sv
// Module: pal_bus_decode
// Turns one bus word into at most one command for the sequencer: an index
// load or a component write. Only full-word writes to the two defined
// offsets count. All other writes produce no command.
// Assumes the bus word is valid for the single cycle in which bus_we is high.
module pal_bus_decode #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = 8,
    parameter int COMP_W    = 8,
    parameter int INDEX_OFS = 0,
    parameter int DATA_OFS  = 4
) (
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  load_idx,
    output logic                  comp_wr,
    output logic [IDX_W-1:0]      new_idx,
    output logic [COMP_W-1:0]     comp_val
);
    localparam int BE_W = DATA_W / 8;
    localparam logic [ADDR_W-1:0] IDX_ADDR  = ADDR_W'(INDEX_OFS);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);

    logic full_word;
    logic unused_low;

    // Accept only accesses that enable every byte lane.
    always_comb full_word = (be == {BE_W{1'b1}});

    // Decode the offset into one of the two commands.
    always_comb begin
        load_idx = we && full_word && (addr == IDX_ADDR);
        comp_wr  = we && full_word && (addr == DATA_ADDR);
    end

    // Payload always comes from the most significant byte of the word.
    always_comb begin
        new_idx  = wdata[DATA_W-1 -: IDX_W];
        comp_val = wdata[DATA_W-1 -: COMP_W];
    end

    assign unused_low = ^wdata[DATA_W-COMP_W-1:0];
endmodule

// File: rtl/pal_sequencer.sv
// Module: pal_sequencer
// Holds the current entry index and the component phase. It issues a one-hot
// component write enable for each data write, advances the phase, and
// increments the index modulo ENTRIES after blue. It also registers the
// update strobe. Assumes load_idx and comp_wr are never both high.
module pal_sequencer
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_idx,
    input  logic [IDX_W-1:0]     new_idx,
    input  logic                 comp_wr,
    output logic [IDX_W-1:0]     cur_idx,
    output phase_e               cur_phase,
    output logic [NUM_COMP-1:0]  comp_we,
    output logic                 upd_valid,
    output logic [IDX_W-1:0]     upd_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] next_idx;
    phase_e           next_phase;
    logic [IDX_W-1:0] inc_idx;

    // Wrap the index after the last entry.
    always_comb inc_idx = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;

    // One-hot component enable: bit 0 red, bit 1 green, bit 2 blue.
    always_comb begin
        comp_we = '0;
        if (comp_wr) begin
            case (cur_phase)
                PH_RED:  comp_we = 3'b001;
                PH_GRN:  comp_we = 3'b010;
                PH_BLU:  comp_we = 3'b100;
                default: comp_we = 3'b000;
            endcase
        end
    end

    // Next index and phase for index loads and component writes.
    always_comb begin
        next_idx   = cur_idx;
        next_phase = cur_phase;
        if (load_idx) begin
            next_idx   = new_idx;
            next_phase = PH_RED;
        end else if (comp_wr) begin
            case (cur_phase)
                PH_RED: next_phase = PH_GRN;
                PH_GRN: next_phase = PH_BLU;
                PH_BLU: begin
                    next_phase = PH_RED;
                    next_idx   = inc_idx;
                end
                default: next_phase = PH_RED;
            endcase
        end
    end

    // State registers for index and phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_phase <= PH_RED;
        end else begin
            cur_idx   <= next_idx;
            cur_phase <= next_phase;
        end
    end

    // One-cycle update strobe carrying the entry that was written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
        end else begin
            upd_valid <= |comp_we;
            upd_idx   <= cur_idx;
        end
    end
endmodule

// File: rtl/pal_store.sv
// Module: pal_store
// Palette storage: one plane of ENTRIES words per colour component, each
// written on its own enable, with an asynchronous read of all three planes
// for the display side. On reset the last entry is white and the rest are
// black. Assumes rd_idx < ENTRIES.
module pal_store
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int COMP_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_COMP-1:0]        comp_we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [COMP_W-1:0]          wr_val,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [NUM_COMP*COMP_W-1:0] rd_color
);
    genvar c;
    generate
        for (c = 0; c < NUM_COMP; c++) begin : g_plane
            logic [COMP_W-1:0] plane [ENTRIES];

            // Reset to the default palette, else write this component.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int e = 0; e < ENTRIES; e++) begin
                        plane[e] <= (e == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
                    end
                end else if (comp_we[c]) begin
                    plane[wr_idx] <= wr_val;
                end
            end

            // Red sits in the top slice, blue in the bottom one.
            assign rd_color[(NUM_COMP-1-c)*COMP_W +: COMP_W] = plane[rd_idx];
        end
    endgenerate
endmodule

// File: rtl/pal_port.sv
// Module: pal_port
// Top of the sequenced palette register port. Connects bus decode,
// index/phase sequencer and component storage. Reads of the window return
// zero. Assumes a single-cycle write protocol on the bus.
module pal_port
    import pal_pkg::*;
#(
    parameter int ENTRIES   = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int COMP_W    = 8,
    parameter int INDEX_OFS = 0,
    parameter int DATA_OFS  = 4,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int BE_W     = DATA_W / 8,
    localparam int COLOR_W  = NUM_COMP * COMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BE_W-1:0]    bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic [COLOR_W-1:0] pix_color,
    output logic               upd_valid,
    output logic [IDX_W-1:0]   upd_idx
);
    logic                load_idx;
    logic                comp_wr;
    logic [IDX_W-1:0]    new_idx;
    logic [COMP_W-1:0]   comp_val;
    logic [IDX_W-1:0]    cur_idx;
    phase_e              cur_phase;
    logic [NUM_COMP-1:0] comp_we;

    // The window has no readable state.
    assign bus_rdata = '0;

    pal_bus_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .COMP_W(COMP_W),
        .INDEX_OFS(INDEX_OFS), .DATA_OFS(DATA_OFS)
    ) u_dec (
        .we(bus_we), .addr(bus_addr), .be(bus_be), .wdata(bus_wdata),
        .load_idx(load_idx), .comp_wr(comp_wr),
        .new_idx(new_idx), .comp_val(comp_val)
    );

    pal_sequencer #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .load_idx(load_idx), .new_idx(new_idx), .comp_wr(comp_wr),
        .cur_idx(cur_idx), .cur_phase(cur_phase), .comp_we(comp_we),
        .upd_valid(upd_valid), .upd_idx(upd_idx)
    );

    pal_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .COMP_W(COMP_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .comp_we(comp_we), .wr_idx(cur_idx), .wr_val(comp_val),
        .rd_idx(pix_idx), .rd_color(pix_color)
    );
endmodule

// File: rtl/pal_port_chk.sv
// Module: pal_port_chk
// Property checker for pal_port, attached by bind. It decodes legal writes
// from the bus itself and relates them to the index, the phase and the
// update strobe one cycle later.
module pal_port_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int IDX_W     = 8,
    parameter int INDEX_OFS = 0,
    parameter int DATA_OFS  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 we,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W/8-1:0]  be,
    input logic [DATA_W-1:0]    wdata,
    input logic [IDX_W-1:0]     idx,
    input logic [1:0]           phase,
    input logic                 upd_valid,
    input logic [IDX_W-1:0]     upd_idx
);
    logic full, w_idx, w_data;
    assign full   = (be == '1);
    assign w_idx  = we && full && (addr == ADDR_W'(INDEX_OFS));
    assign w_data = we && full && (addr == ADDR_W'(DATA_OFS));

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        w_idx |=> (idx == $past(wdata[DATA_W-1 -: IDX_W])) && (phase == 2'd0));

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_data && phase == 2'd0) |=> (phase == 2'd1) && $stable(idx));

    assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_data && phase == 2'd2) |=> (phase == 2'd0) && (idx == IDX_W'($past(idx) + 1'b1)));

    assert_bad_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && full && !w_idx && !w_data) |=> $stable(idx) && $stable(phase) && !upd_valid);

    assert_partial_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !full) |=> $stable(idx) && $stable(phase) && !upd_valid);

    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        w_data |=> upd_valid && (upd_idx == $past(idx)));

    assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !w_data |=> !upd_valid);
endmodule

bind pal_port pal_port_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .INDEX_OFS(INDEX_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .idx(cur_idx), .phase(cur_phase),
    .upd_valid(upd_valid), .upd_idx(upd_idx)
);

// File: tb/sim_pal_port.sv
`timescale 1ns/1ps
module sim_pal_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_color;
    logic        upd_valid;
    logic [7:0]  upd_idx;

    int checks = 0;
    int fails  = 0;

    logic [23:0] m_pal [256];
    logic [7:0]  m_idx;
    int          m_ph;
    logic [7:0]  exp_q [$];

    always #2.5 clk = ~clk;

    pal_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_color(pix_color),
        .upd_valid(upd_valid), .upd_idx(upd_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one bus word per edge; updates the model and the scoreboard.
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        if (be == 4'hF && a == 4'd0) begin
            m_idx = d[31:24]; m_ph = 0;
        end else if (be == 4'hF && a == 4'd4) begin
            exp_q.push_back(m_idx);
            case (m_ph)
                0: m_pal[m_idx][23:16] = d[31:24];
                1: m_pal[m_idx][15:8]  = d[31:24];
                default: m_pal[m_idx][7:0] = d[31:24];
            endcase
            if (m_ph == 2) begin m_idx = m_idx + 8'd1; m_ph = 0; end
            else m_ph++;
        end
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_entry(input logic [7:0] i, input string req);
        @(negedge clk);
        pix_idx = i;
        #1 chk(pix_color == m_pal[i], req, {8'h0, pix_color}, {8'h0, m_pal[i]});
    endtask

    // Monitor: every strobe must match the next expected entry (R8).
    always @(negedge clk) begin
        if (rst_n && upd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected strobe", {24'h0, upd_idx}, 32'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(upd_idx == e, "R8 strobe index", {24'h0, upd_idx}, {24'h0, e});
            end
        end
    end

    initial begin
        #500000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int e = 0; e < 256; e++) m_pal[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
        m_idx = 0; m_ph = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset contents
        check_entry(8'd0, "R1 entry 0");
        check_entry(8'd128, "R1 entry 128");
        check_entry(8'd254, "R1 entry 254");
        check_entry(8'd255, "R1 entry 255 white");
        chk(upd_valid == 1'b0, "R8 idle after reset", {31'h0, upd_valid}, 32'h0);
        chk(bus_rdata == 32'h0, "R7 rdata after reset", bus_rdata, 32'h0);

        // R1/R3: data writes without an index write land in entry 0
        bus_wr(4'd4, 32'h11AAAAAA, 4'hF);
        bus_wr(4'd4, 32'h22555555, 4'hF);
        bus_wr(4'd4, 32'h33000000, 4'hF);
        idle(1);
        check_entry(8'd0, "R3 entry 0 rgb");
        chk(bus_rdata == 32'h0, "R7 rdata after writes", bus_rdata, 32'h0);

        // R4: index followed from 0 to 1 after blue
        bus_wr(4'd4, 32'h44000000, 4'hF);
        idle(1);
        check_entry(8'd1, "R4 auto advance to 1");

        // R2/R3: index load then back-to-back triplets
        bus_wr(4'd0, 32'h10FFFFFF, 4'hF);
        for (int k = 0; k < 6; k++) bus_wr(4'd4, {8'(8'h50 + k), 24'h0}, 4'hF);
        idle(1);
        check_entry(8'h10, "R3 entry 0x10");
        check_entry(8'h11, "R4 entry 0x11 after advance");

        // R4: wrap from 255 to 0
        bus_wr(4'd0, 32'hFF000000, 4'hF);
        bus_wr(4'd4, 32'h01000000, 4'hF);
        bus_wr(4'd4, 32'h02000000, 4'hF);
        bus_wr(4'd4, 32'h03000000, 4'hF);
        bus_wr(4'd4, 32'hC0000000, 4'hF);
        idle(1);
        check_entry(8'hFF, "R4 entry 255 rewritten");
        check_entry(8'h00, "R4 wrap red into entry 0");

        // R2: reload mid-sequence restarts at red
        bus_wr(4'd0, 32'h05000000, 4'hF);
        bus_wr(4'd4, 32'h77000000, 4'hF);
        bus_wr(4'd0, 32'h07000000, 4'hF);
        bus_wr(4'd4, 32'h88000000, 4'hF);
        idle(1);
        check_entry(8'h05, "R2 entry 5 red only");
        check_entry(8'h07, "R2 entry 7 red after reload");

        // R5: other offsets ignored; phase stays at green of entry 7
        bus_wr(4'd8,  32'h99000000, 4'hF);
        bus_wr(4'd12, 32'h99000000, 4'hF);
        bus_wr(4'd5,  32'h99000000, 4'hF);
        bus_wr(4'd1,  32'h20000000, 4'hF);
        idle(1);
        check_entry(8'h07, "R5 entry 7 untouched");
        check_entry(8'h20, "R5 entry 0x20 untouched");
        bus_wr(4'd4, 32'hAB000000, 4'hF);
        idle(1);
        check_entry(8'h07, "R5 green follows after ignored writes");

        // R6: partial byte enables ignored at both offsets
        bus_wr(4'd4, 32'hEE000000, 4'h8);
        bus_wr(4'd0, 32'h30000000, 4'h7);
        bus_wr(4'd4, 32'hEE000000, 4'hE);
        idle(1);
        check_entry(8'h07, "R6 entry 7 unchanged");
        bus_wr(4'd4, 32'hCD000000, 4'hF);
        idle(1);
        check_entry(8'h07, "R6 blue follows after partial writes");
        check_entry(8'h08, "R6 index advanced to 8 only");
        chk(bus_rdata == 32'h0, "R7 rdata at end", bus_rdata, 32'h0);

        idle(2);
        chk(exp_q.size() == 0, "R8 all strobes seen", exp_q.size(), 32'h0);
        chk(upd_valid == 1'b0, "R8 strobe low when idle", {31'h0, upd_valid}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule